// File: doc/BRIEF.md
# Bit-Serial Shift-Register Adder

This block adds two unsigned `WIDTH`-bit words using one full-adder cell and a carry flip-flop. It works on one bit position per clock. The augend sits in shift register A and the addend in shift register B. Both registers shift right, so the least significant bits meet first. On every shift the adder takes the low bit of A, the low bit of B and the stored carry. The sum bit enters the top of A, and the carry is captured for the next step. After `WIDTH` shifts, A holds the sum and the carry flip-flop holds the carry out of the whole word. While B shifts, it refills from an external serial line.

A controller with three named states sequences the block:

- `ST_IDLE` waits for a load or a start request. A load writes both registers in parallel and clears the carry. A start clears the carry and moves to `ST_RUN`. If both requests are present, the load wins and the block stays in `ST_IDLE`.
- `ST_RUN` shifts once per cycle. A cycle counter sends it to `ST_FIN` after the last of `WIDTH` shifts.
- `ST_FIN` raises the done flag for one cycle and returns to `ST_IDLE`.

Requests that arrive outside `ST_IDLE` are dropped.

Top module: `serial_adder`

## Requirements
- R1: After reset, `sum_o`, `b_o` and `carry_o` are all zero, and `busy_o` and `done_o` are low.
- R2: A `load_i` request in idle copies `a_i` into A and `b_i` into B and clears the carry. The new values show on `sum_o`, `b_o` and `carry_o` in the following cycle. If `load_i` and `start_i` are both present in idle, the load is taken and no addition starts.
- R3: A `start_i` request in idle (with `load_i` low) clears the carry. `busy_o` is then high for exactly `WIDTH` consecutive cycles, one shift per cycle.
- R4: On each shift, A moves right by one bit. Its new most significant bit is the full-adder sum of A bit 0, B bit 0 and the stored carry, so the low-order bits are added first.
- R5: On each shift, the carry flip-flop takes the full-adder carry, and `carry_o` shows it. For A=4 and B=7, `carry_o` reads 0, 0, 1, 0 after shifts 1 to 4.
- R6: On each shift, B moves right by one bit and takes `b_ser_i` into its most significant bit. If `b_ser_i` is held at one value for a whole addition, B ends filled with that bit.
- R7: When the addition ends, `sum_o` equals (A+B) mod 2^`WIDTH` of the loaded operands, and `carry_o` equals bit `WIDTH` of the full sum. Example: all-ones plus one gives sum 0 and carry 1.
- R8: `done_o` is high for exactly one cycle, the cycle right after the last shift. It is never high in two consecutive cycles.
- R9: `load_i` and `start_i` have no effect while `busy_o` or `done_o` is high. Such a request changes neither the result nor the number of shift cycles.
- R10: In idle with no request, A, B and the carry hold their values whatever `b_ser_i` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Parallel load request |
| start_i | input | 1 | Start-addition request |
| a_i | input | WIDTH | Parallel value for A (augend) |
| b_i | input | WIDTH | Parallel value for B (addend) |
| b_ser_i | input | 1 | Serial fill bit for B's top stage |
| sum_o | output | WIDTH | Contents of A (holds the sum when done) |
| b_o | output | WIDTH | Contents of B |
| carry_o | output | 1 | Carry flip-flop (carry out after the last shift) |
| busy_o | output | 1 | High while shifting |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions take `load_i`, `start_i` and `b_ser_i` to be known, synchronous levels. They also assume nothing outside the block alters A, B or the carry. Under those assumptions, the carry clears in the cycle after a load or start, and it holds while idle. The stimulus changes every input only on the falling clock edge and holds it for full cycles. It also asserts stray load and start requests during `ST_RUN` and `ST_FIN`, so that the ignore path is exercised and not simply assumed.

// File: rtl/serial_adder_pkg.sv
package serial_adder_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } add_state_e;
endpackage

// File: rtl/serial_add_sreg.sv
module serial_add_sreg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic             shift_en,
    input  logic [WIDTH-1:0] par_i,
    input  logic             ser_i,
    output logic [WIDTH-1:0] q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= '0;
        end else if (load_en) begin
            q_o <= par_i;
        end else if (shift_en) begin
            q_o <= {ser_i, q_o[WIDTH-1:1]};
        end
    end

    // R10: contents hold with no load and no shift
    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !shift_en) |=> $stable(q_o));
    // R6: the serial input lands in the top stage on a shift
    p_ser_enters_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !load_en) |=> (q_o[WIDTH-1] == $past(ser_i)));
endmodule

// File: rtl/serial_add_cell.sv
module serial_add_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic shift_en,
    input  logic a_bit,
    input  logic b_bit,
    output logic sum_bit,
    output logic carry_o
);
    logic carry_nxt;

    always_comb begin
        sum_bit   = a_bit ^ b_bit ^ carry_o;
        carry_nxt = (a_bit & b_bit) | (carry_o & (a_bit ^ b_bit));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            carry_o <= 1'b0;
        end else if (clr) begin
            carry_o <= 1'b0;
        end else if (shift_en) begin
            carry_o <= carry_nxt;
        end
    end

    // R2/R3: a load or start leaves a cleared carry
    p_carry_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !carry_o);
    // R10: carry holds outside a shift
    p_carry_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !shift_en) |=> $stable(carry_o));
    // R5: carry can only rise when at least one operand bit is set
    p_carry_gen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !clr && !a_bit && !b_bit) |=> !carry_o);
endmodule

// File: rtl/serial_add_ctrl.sv
module serial_add_ctrl
    import serial_adder_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic start_i,
    output logic load_en,
    output logic shift_en,
    output logic clr_carry,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    add_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q == ST_RUN) ? cnt_q + 1'b1 : '0;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (!load_i && start_i) state_d = ST_RUN;
            ST_RUN:  if (cnt_q == LAST)      state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load_en   = 1'b0;
        clr_carry = 1'b0;
        shift_en  = 1'b0;
        busy_o    = 1'b0;
        done_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load_en   = load_i;
                clr_carry = load_i | start_i;
            end
            ST_RUN: begin
                shift_en = 1'b1;
                busy_o   = 1'b1;
            end
            ST_FIN:  done_o = 1'b1;
            default: ;
        endcase
    end

    // R8: done is a single-cycle pulse following a shift cycle
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_after_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(shift_en));
    // R9: no load while an addition is running or finishing
    p_no_load_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o || done_o) |-> !load_en);
    // R3: counter stays within the shift window
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |-> (cnt_q <= LAST));
endmodule

// File: rtl/serial_adder.sv
module serial_adder #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             start_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             b_ser_i,
    output logic [WIDTH-1:0] sum_o,
    output logic [WIDTH-1:0] b_o,
    output logic             carry_o,
    output logic             busy_o,
    output logic             done_o
);
    logic load_en, shift_en, clr_carry, sum_bit;
    logic [WIDTH-1:0] a_q, b_q;

    serial_add_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_i(start_i),
        .load_en(load_en), .shift_en(shift_en), .clr_carry(clr_carry),
        .busy_o(busy_o), .done_o(done_o)
    );

    serial_add_sreg #(.WIDTH(WIDTH)) u_reg_a (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .shift_en(shift_en),
        .par_i(a_i), .ser_i(sum_bit), .q_o(a_q)
    );

    serial_add_sreg #(.WIDTH(WIDTH)) u_reg_b (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .shift_en(shift_en),
        .par_i(b_i), .ser_i(b_ser_i), .q_o(b_q)
    );

    serial_add_cell u_cell (
        .clk(clk), .rst_n(rst_n), .clr(clr_carry), .shift_en(shift_en),
        .a_bit(a_q[0]), .b_bit(b_q[0]), .sum_bit(sum_bit), .carry_o(carry_o)
    );

    assign sum_o = a_q;
    assign b_o   = b_q;

    // R4: the sum bit from the cell enters A's top stage on every shift
    p_sum_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (a_q[WIDTH-1] == $past(sum_bit)));
    // R4: A moves right by one on a shift
    p_a_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (a_q[WIDTH-2:0] == $past(a_q[WIDTH-1:1])));
endmodule

// File: tb/serial_adder_tb_top.sv
`timescale 1ns/1ps
module serial_adder_tb_top;
    localparam int W = 8;

    typedef struct packed {
        logic [W-1:0] sum;
        logic         carry;
        logic [W-1:0] bfill;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load_i = 1'b0, start_i = 1'b0, b_ser_i = 1'b0;
    logic [W-1:0] a_i = '0, b_i = '0;
    logic [W-1:0] sum_o, b_o;
    logic carry_o, busy_o, done_o;

    int checks = 0;
    int fails  = 0;
    exp_t sb_q[$];
    int busy_cnt = 0;
    logic prev_done = 1'b0;

    always #2.5 clk = ~clk;

    serial_adder #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_i(start_i),
        .a_i(a_i), .b_i(b_i), .b_ser_i(b_ser_i), .sum_o(sum_o), .b_o(b_o),
        .carry_o(carry_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input logic [W:0] act, input logic [W:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard when a result is announced
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(sum_o == e.sum, "R7 sum", {1'b0, sum_o}, {1'b0, e.sum});
                    chk(carry_o == e.carry, "R7 carry", {{W{1'b0}}, carry_o}, {{W{1'b0}}, e.carry});
                    chk(b_o == e.bfill, "R6 b fill", {1'b0, b_o}, {1'b0, e.bfill});
                end
                chk(busy_cnt == W, "R3 busy cycles", (W+1)'(busy_cnt), (W+1)'(W));
                busy_cnt = 0;
            end
            if (prev_done && done_o) chk(1'b0, "R8 done twice", 1, 0);
            if (busy_o) busy_cnt++;
            prev_done = done_o;
        end
    end

    task automatic load_ops(input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk); load_i = 1'b1; a_i = a; b_i = b;
        @(negedge clk); load_i = 1'b0;
        chk(sum_o == a && b_o == b && !carry_o, "R2 load", {carry_o, sum_o ^ b_o}, {1'b0, a ^ b});
    endtask

    task automatic do_add(input logic [W-1:0] a, input logic [W-1:0] b, input logic s, input bit disturb);
        exp_t e;
        logic [W:0] full;
        load_ops(a, b);
        full = {1'b0, a} + {1'b0, b};
        e.sum = full[W-1:0]; e.carry = full[W]; e.bfill = {W{s}};
        sb_q.push_back(e);
        start_i = 1'b1; b_ser_i = s;
        @(negedge clk); start_i = 1'b0;
        if (disturb) begin
            // R9: stray requests mid-run
            @(negedge clk); load_i = 1'b1; start_i = 1'b1; a_i = ~a; b_i = ~b;
            @(negedge clk); load_i = 1'b0; start_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
        if (disturb) begin
            // R9: stray load during the done cycle
            load_i = 1'b1; a_i = ~a;
            @(negedge clk); load_i = 1'b0;
            chk(sum_o == e.sum, "R9 load in done cycle", {1'b0, sum_o}, {1'b0, e.sum});
        end else begin
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [3:0] ctrace;
        repeat (3) @(negedge clk);
        chk(sum_o == 0 && b_o == 0 && !carry_o && !busy_o && !done_o, "R1 reset",
            {carry_o, sum_o | b_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: worked example 4 + 7, carry trace 0,0,1,0
        load_ops(8'd4, 8'd7);
        sb_q.push_back('{sum: 8'd11, carry: 1'b0, bfill: 8'h00});
        start_i = 1'b1; b_ser_i = 1'b0;
        @(negedge clk); start_i = 1'b0;
        ctrace = 4'b0100;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(carry_o == ctrace[k], "R5 carry step", {{W{1'b0}}, carry_o}, {{W{1'b0}}, ctrace[k]});
        end
        // R4: after 4 shifts the upper half of A holds the low sum nibble 1011
        chk(sum_o[W-1:W-4] == 4'b1011, "R4 lsb first", {5'b0, sum_o[W-1:W-4]}, 9'b1011);
        while (!done_o) @(negedge clk);
        @(negedge clk);

        // R7: all-ones plus one
        do_add('1, 8'd1, 1'b1, 1'b0);
        chk(carry_o == 1'b1, "R7 carry held", {{W{1'b0}}, carry_o}, 1);
        // R10: idle hold while b_ser_i toggles
        for (int k = 0; k < 4; k++) begin
            b_ser_i = ~b_ser_i;
            @(negedge clk);
        end
        chk(sum_o == 0 && b_o == '1 && carry_o, "R10 idle hold", {carry_o, sum_o}, {1'b1, {W{1'b0}}});
        // R2: load with start together: load wins, carry cleared, no run
        @(negedge clk); load_i = 1'b1; start_i = 1'b1; a_i = 8'h5A; b_i = 8'h3C;
        @(negedge clk); load_i = 1'b0; start_i = 1'b0;
        chk(sum_o == 8'h5A && !carry_o && !busy_o, "R2 load priority", {busy_o | carry_o, sum_o}, {1'b0, 8'h5A});
        @(negedge clk);
        chk(!busy_o, "R2 no start", {{W{1'b0}}, busy_o}, 0);

        // R9: disturbed run
        do_add(8'hC3, 8'h7E, 1'b0, 1'b1);
        do_add(8'h80, 8'h80, 1'b1, 1'b0);
        do_add(8'h00, 8'h00, 1'b0, 1'b0);

        // random pairs
        for (int n = 0; n < 24; n++) begin
            do_add(W'($urandom), W'($urandom), 1'($urandom), (n % 5) == 0);
        end

        repeat (3) @(negedge clk);
        chk(sb_q.size() == 0, "R8 all results seen", (W+1)'(sb_q.size()), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule